// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block is the digital controller for one H-bridge that drives a single winding of a current-regulated motor. It receives a comparator output that has already been synchronized to its clock and goes high when the winding current reaches the programmed limit. From the step translator it takes the current direction and the decay style. It also takes an enable and a fault flag. From these it produces four gate commands: high and low side of leg A, and high and low side of leg B.

Each chopping period has three parts. First an on-phase drives one diagonal of the bridge, and the comparator is masked for a programmable blanking window at its start. When the comparator trips after blanking, the on-phase ends. A fixed off-time of programmable length follows. In slow decay the winding recirculates through both low-side FETs. In mixed decay the off-time opens with a fast-decay portion, 5/16 of its length, that drives the opposite diagonal, and the rest of the off-time is slow decay. The recirculating FETs are driven as synchronous rectifiers. They are dropped for the rest of the off-time once a zero-current indication arrives. Each leg has its own crossover guard that holds a FET off until its leg has been idle for the dead time. Off-time, blank time and dead time are counted in clock cycles.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four gates are low. The first on-phase starts on the first edge after release with `drive_en` high and `fault` low. Its gates appear only after the dead-time wait of R8, counted from reset.
- R2: In the on-phase, `dir_pos`=1 turns on `gate_hi_a` and `gate_lo_b`, and `dir_pos`=0 turns on `gate_hi_b` and `gate_lo_a`. The leg whose high side is on is the source leg, and the other leg is the sink leg.
- R3: An off-time lasts exactly OFF_CYC cycles. The on-phase entered when it ends starts a fresh blanking window.
- R4: `sense_trip` is ignored during the first BLANK_CYC cycles of an on-phase. A trip present in the cycle after those ends the on-phase at that edge, even if it was already present during blanking.
- R5: Slow decay turns off the source high side, keeps the sink low side on and turns on the source low side as a rectifier.
- R6: When `decay_mixed`=1, the first FAST_CYC = OFF_CYC*FAST_NUM/FAST_DEN cycles of the off-time (10 of 32 in the bench) turn on the opposite diagonal: the sink high side and the source low side. Slow decay fills the rest of the off-time.
- R7: Once `zero_cur` is seen high at an edge during an off-time, the rectifying FETs stay off until that off-time ends. This means all gates are off in the fast portion, and only the sink low side remains on in slow decay.
- R8: The two FETs of a leg are never on together. A FET turns on only after both FETs of its leg have been off for DEAD_CYC+1 consecutive cycles.
- R9: `drive_en` low or `fault` high forces all four gates low in the same cycle. When both clear, a new on-phase starts.
- R10: `dir_pos` and `decay_mixed` are sampled only at the edge that starts an on-phase. Changes during an on-phase or off-time take effect at the next on-phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_en | input | 1 | Bridge enable; low forces gates off |
| fault | input | 1 | Fault flag; high forces gates off |
| sense_trip | input | 1 | Synchronized current-limit comparator |
| zero_cur | input | 1 | Zero-current indication for rectifier cut-off |
| dir_pos | input | 1 | Winding current direction |
| decay_mixed | input | 1 | 1 = mixed decay, 0 = slow decay |
| gate_hi_a | output | 1 | Leg A high-side gate |
| gate_lo_a | output | 1 | Leg A low-side gate |
| gate_hi_b | output | 1 | Leg B high-side gate |
| gate_lo_b | output | 1 | Leg B low-side gate |

## Verification
Two events can land on the same edge. One is a trip that arrives exactly on the cycle that ends blanking. The other is a kill (enable drop or fault) that arrives on the cycle an off-time expires or a trip is taken. Directed cases hold `sense_trip` high through whole on-phases so that every on-phase ends on the first unmasked cycle. Random single-cycle faults and enable drops are laid over running chopping, so they collide with phase changes. A cycle model in the bench predicts the four gates on every cycle, and each kill collision is judged on whether the gates fall in that same cycle and how the next on-phase restarts.

// File: rtl/chop_pkg.sv
// Shared types for the bridge chopper: sequencer phases and per-leg drive pair.
package chop_pkg;
    typedef enum logic [1:0] {
        PH_HALT = 2'd0,
        PH_ON   = 2'd1,
        PH_FAST = 2'd2,
        PH_SLOW = 2'd3
    } chop_ph_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drv_t;
endpackage

// File: rtl/chop_sequencer.sv
// Phase sequencer: on-phase with comparator blanking, then a fixed off-time
// split into an optional fast portion and a slow portion.
// Assumes: sense_trip and zero_cur already synchronous to clk, FAST_NUM < FAST_DEN,
// BLANK_CYC >= 1, OFF_CYC >= 2.
module chop_sequencer
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 6000,
    parameter int BLANK_CYC = 200,
    parameter int FAST_NUM  = 5,
    parameter int FAST_DEN  = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     kill,
    input  logic     sense_trip,
    input  logic     zero_cur,
    input  logic     dir_pos,
    input  logic     decay_mixed,
    output chop_ph_e ph_o,
    output logic     pol_o,
    output logic     zc_o
);
    localparam int FAST_CYC = (OFF_CYC * FAST_NUM) / FAST_DEN;
    localparam int CMAX     = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW       = $clog2(CMAX + 1);
    localparam logic [CW-1:0] BLANK_V   = CW'(BLANK_CYC);
    localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'((FAST_CYC > 0) ? FAST_CYC - 1 : 0);
    localparam bit HAS_FAST = (FAST_CYC > 0);

    chop_ph_e        ph_q;
    logic [CW-1:0]   cnt_q;
    logic            pol_q;
    logic            mix_q;
    logic            zc_q;

    // Advance the phase machine and its shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_HALT;
            cnt_q <= '0;
            pol_q <= 1'b0;
            mix_q <= 1'b0;
            zc_q  <= 1'b0;
        end else if (kill) begin
            ph_q  <= PH_HALT;
            cnt_q <= '0;
            zc_q  <= 1'b0;
        end else begin
            case (ph_q)
                PH_HALT: begin
                    ph_q  <= PH_ON;
                    cnt_q <= '0;
                    pol_q <= dir_pos;
                    mix_q <= decay_mixed;
                    zc_q  <= 1'b0;
                end
                PH_ON: begin
                    if (cnt_q != BLANK_V) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (sense_trip) begin
                        ph_q  <= (mix_q && HAS_FAST) ? PH_FAST : PH_SLOW;
                        cnt_q <= '0;
                    end
                end
                PH_FAST: begin
                    cnt_q <= cnt_q + 1'b1;
                    zc_q  <= zc_q | zero_cur;
                    if (cnt_q == FAST_LAST) ph_q <= PH_SLOW;
                end
                PH_SLOW: begin
                    if (cnt_q == OFF_LAST) begin
                        ph_q  <= PH_ON;
                        cnt_q <= '0;
                        pol_q <= dir_pos;
                        mix_q <= decay_mixed;
                        zc_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        zc_q  <= zc_q | zero_cur;
                    end
                end
                default: ph_q <= PH_HALT;
            endcase
        end
    end

    assign ph_o  = ph_q;
    assign pol_o = pol_q;
    assign zc_o  = zc_q;

    // R3: the slow portion hands back to an on-phase only after the full off-time.
    p_off_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ON && $past(ph_q) == PH_SLOW) |-> ($past(cnt_q) == OFF_LAST));

    // R4: no exit from the on-phase while blanking is running.
    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ON && cnt_q != BLANK_V && !kill) |=> (ph_q == PH_ON));

    // R6: fast portion length.
    p_fast_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SLOW && $past(ph_q) == PH_FAST) |-> ($past(cnt_q) == FAST_LAST));

    // R10: direction and decay style frozen inside the off-time.
    p_pol_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_q == PH_FAST || ph_q == PH_SLOW) &&
         ($past(ph_q) == PH_FAST || $past(ph_q) == PH_SLOW))
        |-> ($stable(pol_q) && $stable(mix_q)));
endmodule

// File: rtl/chop_pattern.sv
// Gate target map: converts phase, latched direction and zero-current flag into
// the wanted drive of each leg. Purely combinational; leg index 0 = A, 1 = B.
module chop_pattern
    import chop_pkg::*;
(
    input  chop_ph_e       ph_i,
    input  logic           pol_i,
    input  logic           zc_i,
    output leg_drv_t [1:0] tgt_o
);
    leg_drv_t src, snk;

    // Select source/sink leg drive for the current phase.
    always_comb begin
        src = '0;
        snk = '0;
        case (ph_i)
            PH_ON: begin
                src.hi = 1'b1;
                snk.lo = 1'b1;
            end
            PH_FAST: begin
                snk.hi = ~zc_i;
                src.lo = ~zc_i;
            end
            PH_SLOW: begin
                snk.lo = 1'b1;
                src.lo = ~zc_i;
            end
            default: ;
        endcase
    end

    // Place source and sink onto legs A and B by direction.
    always_comb begin
        tgt_o[0] = pol_i ? src : snk;
        tgt_o[1] = pol_i ? snk : src;
    end
endmodule

// File: rtl/chop_dead_guard.sv
// Crossover guard for one leg: follows the wanted drive, but a FET switches on
// only after both FETs of the leg have been off for DEAD_CYC+1 cycles.
// Turn-off is immediate. Assumes DEAD_CYC >= 1 and the target never asks for both.
module chop_dead_guard
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 95
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     kill,
    input  leg_drv_t tgt_i,
    output leg_drv_t act_o
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

    leg_drv_t      act_q;
    logic [DW-1:0] quiet_q;
    logic          ready;

    assign ready = (quiet_q == DEAD_V);

    // Count idle cycles of the leg, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n)                   quiet_q <= '0;
        else if (act_q.hi | act_q.lo) quiet_q <= '0;
        else if (!ready)              quiet_q <= quiet_q + 1'b1;
    end

    // Update the leg drive: hold, drop, or switch on once the leg is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            act_q <= '0;
        end else begin
            act_q.hi <= tgt_i.hi & (act_q.hi | (~act_q.lo & ready));
            act_q.lo <= tgt_i.lo & (act_q.lo | (~act_q.hi & ready));
        end
    end

    assign act_o = act_q;

    // R8: a rising FET had its partner off on the two preceding cycles.
    p_dead_gap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q.hi) |-> (!$past(act_q.lo) && !$past(act_q.lo, 2)));
    p_dead_gap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q.lo) |-> (!$past(act_q.hi) && !$past(act_q.hi, 2)));
endmodule

// File: rtl/chop_bridge_ctrl.sv
// Top of the fixed off-time chopper for one H-bridge: sequencer, target map and
// one crossover guard per leg. Gates are masked combinationally by enable/fault.
// Assumes BLANK_CYC exceeds DEAD_CYC so blanking covers the delayed switching.
module chop_bridge_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_CYC   = 6000,
    parameter int BLANK_CYC = 200,
    parameter int DEAD_CYC  = 95,
    parameter int FAST_NUM  = 5,
    parameter int FAST_DEN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic fault,
    input  logic sense_trip,
    input  logic zero_cur,
    input  logic dir_pos,
    input  logic decay_mixed,
    output logic gate_hi_a,
    output logic gate_lo_a,
    output logic gate_hi_b,
    output logic gate_lo_b
);
    logic           kill;
    chop_ph_e       ph;
    logic           pol;
    logic           zc;
    leg_drv_t [1:0] tgt;
    leg_drv_t [1:0] act;

    assign kill = ~drive_en | fault;

    chop_sequencer #(
        .OFF_CYC   (OFF_CYC),
        .BLANK_CYC (BLANK_CYC),
        .FAST_NUM  (FAST_NUM),
        .FAST_DEN  (FAST_DEN)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill        (kill),
        .sense_trip  (sense_trip),
        .zero_cur    (zero_cur),
        .dir_pos     (dir_pos),
        .decay_mixed (decay_mixed),
        .ph_o        (ph),
        .pol_o       (pol),
        .zc_o        (zc)
    );

    chop_pattern u_pat (
        .ph_i  (ph),
        .pol_i (pol),
        .zc_i  (zc),
        .tgt_o (tgt)
    );

    for (genvar g = 0; g < 2; g++) begin : g_leg
        chop_dead_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (kill),
            .tgt_i (tgt[g]),
            .act_o (act[g])
        );
    end

    assign gate_hi_a = act[0].hi & ~kill;
    assign gate_lo_a = act[0].lo & ~kill;
    assign gate_hi_b = act[1].hi & ~kill;
    assign gate_lo_b = act[1].lo & ~kill;

    // R8: no leg ever conducts through both FETs at the ports.
    p_no_shoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a) && !(gate_hi_b && gate_lo_b));
endmodule

// File: tb/chop_bridge_ctrl_tb_top.sv
`timescale 1ns/1ps
module chop_bridge_ctrl_tb_top;
    localparam int OFF   = 32;
    localparam int BLANK = 6;
    localparam int DEAD  = 2;
    localparam int FAST  = (OFF * 5) / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, flt = 1'b0, trip = 1'b0, zc = 1'b0, pol = 1'b1, mix = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chop_bridge_ctrl #(
        .OFF_CYC(OFF), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD), .FAST_NUM(5), .FAST_DEN(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .drive_en(en), .fault(flt), .sense_trip(trip),
        .zero_cur(zc), .dir_pos(pol), .decay_mixed(mix),
        .gate_hi_a(hs_a), .gate_lo_a(ls_a), .gate_hi_b(hs_b), .gate_lo_b(ls_b)
    );

    // Reference model; gate vector order {hs_a, ls_a, hs_b, ls_b}.
    int       m_ph = 0;    // 0 halted, 1 on, 2 fast, 3 slow
    int       m_cnt = 0;
    bit       m_pol = 0, m_mix = 0, m_zc = 0;
    bit [3:0] m_gate = '0;
    int       m_quiet [2] = '{0, 0};

    function automatic bit [3:0] want(int ph, bit p, bit z);
        bit [3:0] w = '0;
        if (ph == 1)      w = p ? 4'b1001 : 4'b0110;
        else if (ph == 2) w = z ? 4'b0000 : (p ? 4'b0110 : 4'b1001);
        else if (ph == 3) w = p ? {1'b0, ~z, 1'b0, 1'b1} : {1'b0, 1'b1, 1'b0, ~z};
        return w;
    endfunction

    function automatic string tag_of(int ph, int c, bit z);
        if (ph == 0) return "R9";
        if (ph == 1) return (c == 0) ? "R10" : ((c < BLANK) ? "R4" : "R2");
        if (z) return "R7";
        if (ph == 2) return "R6";
        return (c == OFF - 1) ? "R3" : "R5";
    endfunction

    always @(posedge clk) begin
        bit [3:0] w, nx;
        bit kill;
        int nq [2];
        cyc = cyc + 1;
        kill = !en || flt;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_pol = 0; m_mix = 0; m_zc = 0;
            m_gate = '0; m_quiet = '{0, 0};
        end else begin
            w = want(m_ph, m_pol, m_zc);
            for (int l = 0; l < 2; l++) begin
                bit ch, cl, wh, wl, ok;
                ch = m_gate[3 - 2*l]; cl = m_gate[2 - 2*l];
                wh = w[3 - 2*l];      wl = w[2 - 2*l];
                ok = (m_quiet[l] == DEAD);
                nx[3 - 2*l] = !kill && wh && (ch || (!cl && ok));
                nx[2 - 2*l] = !kill && wl && (cl || (!ch && ok));
                nq[l] = (ch || cl) ? 0 : (ok ? DEAD : m_quiet[l] + 1);
            end
            m_gate = nx;
            m_quiet = nq;
            if (kill) begin
                m_ph = 0; m_cnt = 0; m_zc = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_cnt = 0; m_pol = pol; m_mix = mix; m_zc = 0;
            end else if (m_ph == 1) begin
                if (m_cnt < BLANK) m_cnt++;
                else if (trip) begin m_ph = (m_mix && FAST > 0) ? 2 : 3; m_cnt = 0; end
            end else if (m_ph == 2) begin
                m_zc = m_zc || zc;
                if (m_cnt == FAST - 1) m_ph = 3;
                m_cnt++;
            end else begin
                if (m_cnt == OFF - 1) begin
                    m_ph = 1; m_cnt = 0; m_pol = pol; m_mix = mix; m_zc = 0;
                end else begin
                    m_cnt++; m_zc = m_zc || zc;
                end
            end
        end
    end

    task automatic check(string req, bit [3:0] act, bit [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gates=%b expected=%b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model plus the crossover invariant.
    always @(negedge clk) begin
        bit [3:0] g, e;
        g = {hs_a, ls_a, hs_b, ls_b};
        if (rst_n && !done) begin
            e = m_gate & {4{en && !flt}};
            check(tag_of(m_ph, m_cnt, m_zc), g, e);
            check("R8", {g[3] & g[2], g[1] & g[0], 2'b00}, 4'b0000);
            if (!en || flt) check("R9", g, 4'b0000);
        end
    end

    task automatic drive(bit e, bit f, bit t, bit z, bit p, bit m, int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            en = e; flt = f; trip = t; zc = z; pol = p; mix = m;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", {hs_a, ls_a, hs_b, ls_b}, 4'b0000);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1: gates stay low through the first dead-time wait.
        for (int i = 0; i < DEAD; i++) begin
            @(negedge clk);
            check("R1", {hs_a, ls_a, hs_b, ls_b}, 4'b0000);
        end
        // R4/R6: trip held high, slow then mixed, both directions.
        drive(1, 0, 1, 0, 1, 0, 3 * (OFF + BLANK + 4));
        drive(1, 0, 1, 0, 0, 1, 3 * (OFF + BLANK + 4));
        // R7: zero-current pulses inside off-times.
        for (int k = 0; k < 6; k++) begin
            drive(1, 0, 1, 0, k[0], 1, BLANK + 3 + k);
            drive(1, 0, 0, 1, k[0], 1, 1);
            drive(1, 0, 0, 0, k[0], 1, OFF);
        end
        // R9: fault coinciding with a trip and an enable drop mid off-time.
        drive(1, 0, 1, 0, 1, 1, BLANK + 1);
        drive(1, 1, 1, 0, 1, 1, 1);
        drive(1, 0, 1, 0, 1, 1, BLANK + 5);
        drive(0, 0, 0, 0, 1, 1, 3);
        drive(1, 0, 0, 0, 0, 0, 2 * OFF);
        // Constrained random chopping.
        for (int k = 0; k < 8000; k++) begin
            bit t, z, f, e;
            t = ($urandom % 6) == 0;
            z = ($urandom % 40) == 0;
            f = ($urandom % 500) == 0;
            e = ($urandom % 400) != 0;
            if (($urandom % 30) == 0) pol = ~pol;
            if (($urandom % 30) == 0) mix = ~mix;
            drive(e, f, t, z, pol, mix, 1);
        end
        drive(1, 0, 0, 0, pol, mix, 4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule